// File: doc/BRIEF.md
# Daisy-Chain Switch Command Port

This block is the serial front end of an eight-channel output switch bank. A controller clocks in a command byte in SPI mode 0. Each bit of the byte turns one channel on or off. In the same frame the block clocks out the channel fault bits that it has latched since the previous frame. When the check-mode pin is high, each frame is followed by a check byte in each direction. Each check byte carries a 5-bit CRC. The check byte sent back also carries three status flags. Data arriving on the serial input reappears on the serial output one frame later. Several devices on one chip select can therefore be chained, and each keeps the last full frame clocked into it.

All serial pins are oversampled in the system clock domain. A frame state machine has five states:

- **IDLE**: waits for chip select low. On chip select low it loads the response and goes to SHIFT.
- **SHIFT**: captures on rising serial clock and drives on falling serial clock. When chip select rises it goes to CHECK.
- **CHECK**: judges the clock count and the CRC. On a good verdict it goes to ACCEPT, otherwise to REJECT.
- **ACCEPT** and **REJECT**: each lasts one cycle and pulses its verdict, then returns to IDLE.

An output state machine has two states:

- **HOLD**: entered when the sync input goes low. The applied outputs are frozen.
- **TRACK**: entered when the sync input goes high. Accepted commands pass straight through to the outputs.

The enable pin gates the outputs combinationally.

Top module: `sw_cmd_spi`

## Requirements
- R1: SDI is captured on each rising CLK edge while chip select is low. The CLK level when chip select falls is ignored, and a falling CLK edge never counts as a bit.
- R2: The check mode is sampled when chip select falls. A frame is accepted only if its count of rising CLK edges is nonzero and a multiple of 8 (check mode off) or of 16 (check mode on). Any other count discards the frame and raises COMERR.
- R3: The command is the last 8 data bits of the frame, sent MSB first as channel 8 down to channel 1. Bit value 1 means on and 0 means off.
- R4: The first 8 SDO bits of a frame are the fault bits, channel 8 first.
- R5: In check mode the last 8 bits of the frame are three zero bits and then the CRC, MSB first. The CRC uses the polynomial x^5+x^4+x^2+1 with seed 11111 and runs over the 8 command bits followed by three zeros. A CRC mismatch or a nonzero pad bit leaves the outputs unchanged and raises COMERR.
- R6: In check mode, SDO bits 9 to 16 are the watchdog error flag, the supply-low flag and the thermal flag, in that order, followed by the CRC of the 8 fault bits and these 3 flags. The CRC uses the same polynomial and seed as in R5, and all 16 bits are sent MSB first.
- R7: A fault bit is latched when its input is seen high. A frame reports the latched value, and the latch is then reloaded from the fault inputs present at that moment. While the thermal flag is high, all 8 reported fault bits are 1.
- R8: SDO changes only after a falling CLK edge or at frame start. SDO repeats SDI delayed by exactly one frame length (8 or 16 bits).
- R9: While the sync input is low, the outputs hold their values. When the sync input rises, the most recent accepted command is applied. While the sync input is high, each accepted command is applied at once.
- R10: While EN is low, all switch outputs are 0 whatever the command or the sync input. When EN returns high, the outputs show the applied command again.
- R11: sdo_oe is 0 whenever chip select is high, and 1 while a frame is in progress.
- R12: COMERR stays set until a frame is accepted without error. An empty or bad frame leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| crc_en | input | 1 | Check-byte mode select |
| sync_in | input | 1 | Output update strobe / level |
| en | input | 1 | Global output enable |
| fault_in | input | 8 | Per-channel fault indications |
| chip_hot | input | 1 | Chip thermal shutdown flag |
| supply_low | input | 1 | Supply below operating threshold |
| wd_err | input | 1 | Watchdog error flag |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO drive enable (0 = high impedance) |
| comerr | output | 1 | Communication error, sticky |
| sw_on | output | 8 | Switch enables, bit 7 = channel 8 |

## Verification
Some properties are checked on every cycle:
- SDO is disabled whenever chip select is high.
- SDO moves only after falling clock edges.
- The bit counter steps once per rising edge.
- A nonzero pad leads to rejection.
- COMERR sets, clears and stays as R2 and R12 require.
- The command register changes only on acceptance.
- Outputs are frozen while sync is low.
- No seen fault is lost from the latch.

The bench scenarios are the only evidence for the rest:
- the CRC values in both directions;
- the exact one-frame delay through a chain;
- acceptance or rejection by clock count;
- the fault clearing sequence;
- the deferred update on a sync rising edge.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int CH_W  = 8;
    localparam int PAD_W = 3;
    localparam int CRC_W = 5;
    localparam int CHK_W = PAD_W + CRC_W;
    localparam int MSG_W = CH_W + PAD_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'b10101;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SHIFT,
        FS_CHECK,
        FS_ACCEPT,
        FS_REJECT
    } frame_state_t;

    typedef enum logic {
        OS_HOLD,
        OS_TRACK
    } out_state_t;

    // serial CRC-5, message consumed MSB first
    function automatic logic [CRC_W-1:0] crc5_calc(input logic [MSG_W-1:0] msg);
        logic [CRC_W-1:0] r;
        logic fb;
        r = CRC_SEED;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ msg[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/swc_fault.sv
module swc_fault
    import swc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] fault_in,
    input  logic            chip_hot,
    input  logic            capture,
    output logic [CH_W-1:0] flt_snap
);
    logic [CH_W-1:0] flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flt_q <= '0;
        else if (capture) flt_q <= fault_in;
        else              flt_q <= flt_q | fault_in;
    end

    assign flt_snap = chip_hot ? {CH_W{1'b1}} : (flt_q | fault_in);

    // a fault seen in one cycle is still held in the next
    p_fault_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> ((flt_q & $past(fault_in)) == $past(fault_in)));
endmodule

// File: rtl/swc_frame.sv
module swc_frame
    import swc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_s,
    input  logic            sck_s,
    input  logic            sdi_s,
    input  logic            crc_en,
    input  logic [CH_W-1:0] flt_snap,
    input  logic            wd_err,
    input  logic            supply_low,
    input  logic            chip_hot,
    output logic            start,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            cmd_ok,
    output logic            cmd_bad,
    output logic [CH_W-1:0] cmd_data
);
    localparam int WIDE_W    = CH_W + CHK_W;
    localparam int NARROW_W  = CH_W;
    localparam int WIDE_LG   = $clog2(WIDE_W);
    localparam int NARROW_LG = $clog2(NARROW_W);

    frame_state_t st_q, st_d;

    logic [WIDE_W-1:0]  sr_q;
    logic [WIDE_LG-1:0] cnt_q;
    logic               any_q;
    logic               wide_q;
    logic               sck_d;
    logic               sdo_q;

    logic               sck_rise, sck_fall;
    logic               cnt_ok, crc_ok, verdict;
    logic [PAD_W-1:0]   stat_bits;
    logic [CHK_W-1:0]   rsp_chk;
    logic [CH_W-1:0]    rx_cmd;
    logic [PAD_W-1:0]   rx_pad;
    logic [CRC_W-1:0]   rx_crc;

    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign stat_bits = {wd_err, supply_low, chip_hot};
    assign rsp_chk   = {stat_bits, crc5_calc({flt_snap, stat_bits})};

    assign rx_cmd = wide_q ? sr_q[WIDE_W-1 -: CH_W] : sr_q[CH_W-1:0];
    assign rx_pad = sr_q[CHK_W-1 -: PAD_W];
    assign rx_crc = sr_q[CRC_W-1:0];

    assign cnt_ok  = any_q && (wide_q ? (cnt_q == '0) : (cnt_q[NARROW_LG-1:0] == '0));
    assign crc_ok  = (rx_pad == '0) && (rx_crc == crc5_calc({rx_cmd, {PAD_W{1'b0}}}));
    assign verdict = cnt_ok && (!wide_q || crc_ok);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE:   if (!cs_s) st_d = FS_SHIFT;
            FS_SHIFT:  if (cs_s)  st_d = FS_CHECK;
            FS_CHECK:  st_d = verdict ? FS_ACCEPT : FS_REJECT;
            FS_ACCEPT: st_d = FS_IDLE;
            FS_REJECT: st_d = FS_IDLE;
            default:   st_d = FS_IDLE;
        endcase
    end

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            any_q  <= 1'b0;
            wide_q <= 1'b0;
            sdo_q  <= 1'b0;
            sck_d  <= 1'b0;
        end else begin
            sck_d <= sck_s;
            unique case (st_q)
                FS_IDLE: begin
                    if (!cs_s) begin
                        wide_q <= crc_en;
                        cnt_q  <= '0;
                        any_q  <= 1'b0;
                        sdo_q  <= flt_snap[CH_W-1];
                        if (crc_en) sr_q <= {flt_snap, rsp_chk};
                        else        sr_q <= {{CHK_W{1'b0}}, flt_snap};
                    end
                end
                FS_SHIFT: begin
                    if (!cs_s) begin
                        if (sck_rise) begin
                            sr_q  <= {sr_q[WIDE_W-2:0], sdi_s};
                            cnt_q <= cnt_q + 1'b1;
                            any_q <= 1'b1;
                        end else if (sck_fall) begin
                            sdo_q <= wide_q ? sr_q[WIDE_W-1] : sr_q[NARROW_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        start    = (st_q == FS_IDLE) && !cs_s;
        sdo      = sdo_q;
        sdo_oe   = (st_q == FS_SHIFT);
        cmd_ok   = (st_q == FS_ACCEPT);
        cmd_bad  = (st_q == FS_REJECT);
        cmd_data = rx_cmd;
    end

    p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_SHIFT && !cs_s && sck_rise) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_sdo_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_SHIFT && !sck_fall) |=> $stable(sdo_q));

    p_pad_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_CHECK && wide_q && rx_pad != '0) |=> cmd_bad);
endmodule

// File: rtl/swc_outctl.sv
module swc_outctl
    import swc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sync_s,
    input  logic            cmd_ok,
    input  logic            cmd_bad,
    input  logic [CH_W-1:0] cmd_data,
    output logic [CH_W-1:0] sw_on,
    output logic            comerr
);
    out_state_t st_q, st_d;

    logic [CH_W-1:0] cmd_q;
    logic [CH_W-1:0] out_q;
    logic            err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OS_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OS_HOLD:  if (sync_s)  st_d = OS_TRACK;
            OS_TRACK: if (!sync_s) st_d = OS_HOLD;
            default:  st_d = OS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            out_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (cmd_ok) cmd_q <= cmd_data;
            if (cmd_ok)       err_q <= 1'b0;
            else if (cmd_bad) err_q <= 1'b1;
            if (st_d == OS_TRACK) out_q <= cmd_q;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < CH_W; gi++) begin : g_gate
            assign sw_on[gi] = en & out_q[gi];
        end
    endgenerate

    assign comerr = err_q;

    p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_s |=> $stable(out_q));

    p_cmd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> $stable(cmd_q));

    p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> comerr);

    p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> !comerr);

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (comerr && !cmd_ok) |=> comerr);
endmodule

// File: rtl/sw_cmd_spi.sv
module sw_cmd_spi
    import swc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            sdi,
    input  logic            crc_en,
    input  logic            sync_in,
    input  logic            en,
    input  logic [CH_W-1:0] fault_in,
    input  logic            chip_hot,
    input  logic            supply_low,
    input  logic            wd_err,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            comerr,
    output logic [CH_W-1:0] sw_on
);
    logic [3:0]      pin_s;
    logic            cs_s, sck_s, sdi_s, sync_s;
    logic            start, cmd_ok, cmd_bad;
    logic [CH_W-1:0] cmd_data;
    logic [CH_W-1:0] flt_snap;

    swc_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, sdi, sync_in}),
        .dout (pin_s)
    );

    assign {cs_s, sck_s, sdi_s, sync_s} = pin_s;

    swc_fault u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_in(fault_in),
        .chip_hot(chip_hot),
        .capture (start),
        .flt_snap(flt_snap)
    );

    swc_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sck_s     (sck_s),
        .sdi_s     (sdi_s),
        .crc_en    (crc_en),
        .flt_snap  (flt_snap),
        .wd_err    (wd_err),
        .supply_low(supply_low),
        .chip_hot  (chip_hot),
        .start     (start),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .cmd_ok    (cmd_ok),
        .cmd_bad   (cmd_bad),
        .cmd_data  (cmd_data)
    );

    swc_outctl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sync_s  (sync_s),
        .cmd_ok  (cmd_ok),
        .cmd_bad (cmd_bad),
        .cmd_data(cmd_data),
        .sw_on   (sw_on),
        .comerr  (comerr)
    );
endmodule

// File: tb/sw_cmd_spi_test.sv
module sw_cmd_spi_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic       crc_en = 1'b0, sync_in = 1'b1, en = 1'b1;
    logic [7:0] fault_in = 8'h00;
    logic       chip_hot = 1'b0, supply_low = 1'b0, wd_err = 1'b0;
    logic       sdo, sdo_oe, comerr;
    logic [7:0] sw_on;

    int         nchk = 0;
    int         nerr = 0;
    bit         done = 1'b0;
    logic [7:0] latch_m = 8'h00;
    logic [63:0] rx;
    logic       oe_mid;

    always #4 clk = ~clk;

    sw_cmd_spi uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .crc_en(crc_en), .sync_in(sync_in), .en(en), .fault_in(fault_in),
        .chip_hot(chip_hot), .supply_low(supply_low), .wd_err(wd_err),
        .sdo(sdo), .sdo_oe(sdo_oe), .comerr(comerr), .sw_on(sw_on)
    );

    function automatic logic [4:0] ref_crc(input logic [10:0] m);
        logic [4:0] r = 5'b11111;
        for (int k = 10; k >= 0; k--) begin
            if (r[4] ^ m[k]) r = {r[3:0], 1'b0} ^ 5'b10101;
            else             r = {r[3:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [15:0] wide_cmd(input logic [7:0] d);
        return {d, 3'b000, ref_crc({d, 3'b000})};
    endfunction

    function automatic logic [15:0] resp_word(input bit wide);
        logic [7:0] fv = chip_hot ? 8'hFF : latch_m;
        logic [2:0] st = {wd_err, supply_low, chip_hot};
        if (wide) return {fv, st, ref_crc({fv, st})};
        return {8'h00, fv};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_faults(input logic [7:0] v);
        fault_in = v;
        latch_m  = latch_m | v;
        repeat (3) @(negedge clk);
    endtask

    // one chip-select frame of n bits, MSB first
    task automatic xfer(input logic [63:0] tx, input int n, input bit start_hi);
        rx = '0;
        @(negedge clk);
        sck = start_hi;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = tx[n-1-i];
            repeat (8) @(negedge clk);
            rx = {rx[62:0], sdo};
            if (i == 0) oe_mid = sdo_oe;
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        sdi  = 1'b0;
        latch_m = fault_in;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp;
        logic [7:0]  held;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk("R11 reset sdo_oe", sdo_oe, 0);
        chk("R10 reset sw_on", sw_on, 0);
        chk("R12 reset comerr", comerr, 0);

        // R1 R3 R4: clock high at chip-select fall, narrow frame
        set_faults(8'h21);
        exp = resp_word(0);
        xfer(64'hA5, 8, 1'b1);
        chk("R4 fault byte", rx[7:0], exp[7:0]);
        chk("R1 R3 command applied", sw_on, 8'hA5);
        chk("R11 oe during frame", oe_mid, 1);
        chk("R11 oe after frame", sdo_oe, 0);

        // random frames in both modes
        for (int it = 0; it < 24; it++) begin
            logic [7:0] d;
            bit w;
            d = 8'($urandom);
            w = 1'($urandom);
            crc_en = w;
            wd_err = 1'($urandom);
            supply_low = 1'($urandom);
            chip_hot = ($urandom % 4) == 0;
            set_faults(8'($urandom));
            exp = resp_word(w);
            if (w) begin
                xfer({48'h0, wide_cmd(d)}, 16, 1'b0);
                chk("R6 R7 wide response", rx[15:0], exp);
            end else begin
                xfer({56'h0, d}, 8, 1'b0);
                chk("R4 R7 narrow response", rx[7:0], exp[7:0]);
            end
            chk("R3 R5 random command", sw_on, d);
        end
        chip_hot = 0; wd_err = 0; supply_low = 0; crc_en = 0;
        set_faults(8'h00);
        xfer(64'h00, 8, 1'b0);

        // R7: latched fault cleared only after it has gone
        set_faults(8'h80);
        fault_in = 8'h00;
        repeat (3) @(negedge clk);
        xfer(64'h11, 8, 1'b0);
        chk("R7 latched fault reported", rx[7:0], 8'h80);
        xfer(64'h11, 8, 1'b0);
        chk("R7 fault cleared next frame", rx[7:0], 8'h00);
        chip_hot = 1;
        xfer(64'h11, 8, 1'b0);
        chk("R7 thermal all ones", rx[7:0], 8'hFF);
        chip_hot = 0;

        // R6 directed status flags
        crc_en = 1; wd_err = 1; supply_low = 0;
        exp = resp_word(1);
        xfer({48'h0, wide_cmd(8'h42)}, 16, 1'b0);
        chk("R6 status check byte", rx[7:0], exp[7:0]);
        chk("R5 good crc accepted", sw_on, 8'h42);
        wd_err = 0;

        // R2 clock count errors, R12 stickiness
        crc_en = 0;
        held = sw_on;
        xfer(64'h0F, 7, 1'b0);
        chk("R2 seven clocks comerr", comerr, 1);
        chk("R2 seven clocks ignored", sw_on, held);
        xfer(64'h0, 0, 1'b0);
        chk("R12 empty frame keeps comerr", comerr, 1);
        chk("R2 empty frame ignored", sw_on, held);
        crc_en = 1;
        xfer(64'h3C, 8, 1'b0);
        chk("R2 eight clocks in check mode", comerr, 1);
        chk("R2 short check frame ignored", sw_on, held);
        xfer({48'h0, wide_cmd(8'h99)}, 16, 1'b0);
        chk("R12 good frame clears comerr", comerr, 0);
        chk("R2 good check frame applied", sw_on, 8'h99);

        // R5 bad CRC and nonzero pad
        xfer({48'h0, wide_cmd(8'h66) ^ 16'h0001}, 16, 1'b0);
        chk("R5 bad crc comerr", comerr, 1);
        chk("R5 bad crc ignored", sw_on, 8'h99);
        xfer({48'h0, 8'h66, 3'b010, ref_crc({8'h66, 3'b010})}, 16, 1'b0);
        chk("R5 nonzero pad ignored", sw_on, 8'h99);
        chk("R5 nonzero pad comerr", comerr, 1);

        // R8 daisy chain delay
        crc_en = 0;
        exp = resp_word(0);
        xfer({48'h0, 8'h3C, 8'hC3}, 16, 1'b0);
        chk("R8 narrow first byte response", rx[15:8], exp[7:0]);
        chk("R8 narrow passthrough", rx[7:0], 8'h3C);
        chk("R8 narrow keeps last byte", sw_on, 8'hC3);
        chk("R12 chain frame clears comerr", comerr, 0);
        crc_en = 1;
        exp = resp_word(1);
        xfer({32'h0, wide_cmd(8'h5E), wide_cmd(8'hE5)}, 32, 1'b0);
        chk("R8 wide response", rx[31:16], exp);
        chk("R8 wide passthrough", rx[15:0], wide_cmd(8'h5E));
        chk("R8 wide keeps last frame", sw_on, 8'hE5);

        // R9 sync gating
        crc_en = 0;
        sync_in = 0;
        repeat (6) @(negedge clk);
        xfer(64'h5A, 8, 1'b0);
        chk("R9 held while sync low", sw_on, 8'hE5);
        repeat (20) @(negedge clk);
        chk("R9 still held", sw_on, 8'hE5);
        sync_in = 1;
        repeat (8) @(negedge clk);
        chk("R9 applied on sync rise", sw_on, 8'h5A);
        sync_in = 0;
        repeat (6) @(negedge clk);
        xfer(64'h11, 8, 1'b0);
        xfer(64'h22, 8, 1'b0);
        chk("R9 two commands held", sw_on, 8'h5A);
        sync_in = 1;
        repeat (8) @(negedge clk);
        chk("R9 latest command on rise", sw_on, 8'h22);

        // R10 enable override
        en = 0;
        repeat (2) @(negedge clk);
        chk("R10 en low forces off", sw_on, 8'h00);
        xfer(64'h77, 8, 1'b0);
        chk("R10 command while disabled", sw_on, 8'h00);
        en = 1;
        repeat (2) @(negedge clk);
        chk("R10 restored after en", sw_on, 8'h77);
        chk("R11 idle oe", sdo_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule